// File: doc/BRIEF.md
# Sensor Configuration SPI Master

This block sits in the host FPGA and writes and reads the configuration registers of a mixed-signal sensor chip over a four-wire serial link. It runs from the same system clock that the FPGA forwards to the chip. It divides that clock by a fixed even ratio, four by default, to make a serial clock whose rising edges line up with rising edges of the system clock. Every transfer is one full word, 32 bits by default, sent and received with the most significant bit first.

A client starts a transfer by presenting a command word and raising a request while the block is idle. The block lowers the active-low chip select, toggles the serial clock once per bit, and sends the command out while it gathers the chip's reply. At the end it raises chip select again and pulses a done strobe for one cycle, with the received word on the read-data output. The outgoing data bit and chip select change only on falling serial-clock edges. The incoming bit is also captured on falling edges, so the chip has half a serial period after each rising edge to drive its output.

Top module: `spi_cfg_master`

## Requirements
- R1: After reset, csn is 1, sclk is 0, busy is 0, done is 0 and rdata is all zeros.
- R2: A request is taken only on a rising clock edge where busy is 0. csn goes low one system clock after that edge, and the first rising sclk edge follows one system clock later. busy is 1 from the cycle after acceptance until the transfer's deselect gap ends.
- R3: While csn is low, sclk has a period of CLK_DIV system clocks, rises on a system-clock rising edge and stays high for the first CLK_DIV/2 clocks of each period. A transfer has exactly WORD_W sclk periods. sclk is 0 whenever csn is 1.
- R4: mosi presents cmd most significant bit first. Bit WORD_W-1 is valid from the fall of csn, and each following bit appears on a falling sclk edge, so mosi never changes while sclk is high.
- R5: miso is sampled on each falling sclk edge. The first sample becomes bit WORD_W-1 of rdata and the last sample becomes bit 0.
- R6: csn returns to 1 on the WORD_W-th falling sclk edge. done is 1 for exactly one system clock, one cycle after csn rises, and rdata holds the received word from that cycle until the next transfer completes.
- R7: After csn rises, busy stays 1 for CLK_DIV more cycles. This leaves csn high for at least CLK_DIV+1 system clocks between two transfers, even when req is held high.
- R8: A request raised while busy is 1 has no effect: the transfer in progress sends its original command and no extra transfer follows.
- R9: CLK_DIV must be even and at least 4, and WORD_W must be at least 2; other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also forwarded to the chip |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transfer request, sampled when idle |
| cmd | input | WORD_W | Command word to send |
| busy | output | 1 | Transfer or deselect gap in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | WORD_W | Word received from the chip |
| csn | output | 1 | Chip select to the chip, active low |
| sclk | output | 1 | Serial clock to the chip |
| mosi | output | 1 | Serial data to the chip |
| miso | input | 1 | Serial data from the chip |

## Verification
The hardest case to reach from the ports is a request that arrives exactly on the edge where the deselect gap ends, because it decides whether back-to-back transfers keep their minimum spacing. The stimulus holds req high across two transfers, so the block sees a request on every edge of the gap. It also pulses a request with a different command in the middle of a transfer. A bench-side chip model drives miso on rising sclk edges and records mosi, so that both serial directions are checked against the words the model chose.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_GAP   = 2'd3
   } xfer_state_t;
endpackage

// File: rtl/spi_clk_phase.sv
module spi_clk_phase #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic sclk,
   output logic fall
);
   localparam int PH_W = $clog2(CLK_DIV);
   localparam int HALF = CLK_DIV / 2;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
   localparam logic [PH_W-1:0] PH_FALL = PH_W'(HALF - 1);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_nxt;

   assign ph_nxt = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
   assign fall   = run && (ph_q == PH_FALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
         sclk <= 1'b0;
      end else if (start) begin
         ph_q <= '0;
         sclk <= 1'b1;
      end else if (run) begin
         ph_q <= ph_nxt;
         sclk <= (ph_nxt < PH_W'(HALF));
      end else begin
         sclk <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_shift_chain.sv
module spi_shift_chain #(
   parameter int LEN = 31
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [LEN-1:0] load_val,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] q
);
   genvar i;
   generate
      for (i = 0; i < LEN; i++) begin : g_stage
         logic feed;
         if (i == 0) begin : g_head
            assign feed = din;
         end else begin : g_body
            assign feed = q[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (load)     q[i] <= load_val[i];
            else if (shift_en) q[i] <= feed;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_cfg_master.sv
module spi_cfg_master
   import spi_cfg_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [WORD_W-1:0] cmd,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rdata,
   output logic              csn,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam int GAP_W = $clog2(CLK_DIV);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
   localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(CLK_DIV - 1);

   // R9: parameter legality
   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 4");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
   endgenerate

   xfer_state_t      state_q, state_d;
   logic [CNT_W-1:0] bit_q;
   logic [GAP_W-1:0] gap_q;
   logic [WORD_W-2:0] sh_q;
   logic             accept, fall, last_fall;

   assign accept    = (state_q == ST_IDLE) && req;
   assign last_fall = fall && (bit_q == LAST_BIT);
   assign busy      = (state_q != ST_IDLE);

   spi_clk_phase #(.CLK_DIV(CLK_DIV)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state_q == ST_SETUP),
      .run   (state_q == ST_SHIFT),
      .sclk  (sclk),
      .fall  (fall)
   );

   spi_shift_chain #(.LEN(WORD_W - 1)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (cmd[WORD_W-2:0]),
      .shift_en (fall),
      .din      (miso),
      .q        (sh_q)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req) state_d = ST_SETUP;
         ST_SETUP: state_d = ST_SHIFT;
         ST_SHIFT: if (last_fall) state_d = ST_GAP;
         ST_GAP:   if (gap_q == GAP_END) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         gap_q   <= '0;
         csn     <= 1'b1;
         mosi    <= 1'b0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == ST_GAP) && (gap_q == '0);
         if (accept) begin
            bit_q <= '0;
            csn   <= 1'b0;
            mosi  <= cmd[WORD_W-1];
         end else if (fall) begin
            bit_q <= bit_q + 1'b1;
            mosi  <= last_fall ? 1'b0 : sh_q[WORD_W-2];
         end
         if (last_fall) begin
            csn   <= 1'b1;
            gap_q <= '0;
            rdata <= {sh_q, miso};
         end else if (state_q == ST_GAP) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_cfg_master_chk.sv
module spi_cfg_master_chk (
   input logic clk,
   input logic rst_n,
   input logic csn,
   input logic sclk,
   input logic mosi,
   input logic busy,
   input logic done
);
   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> !sclk);

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   assert_select_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !csn |-> busy);

   assert_csn_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csn) |-> $fell(sclk));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_csn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (csn && $past(csn) && !$past(csn, 2)));

   assert_gap_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

bind spi_cfg_master spi_cfg_master_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .csn   (csn),
   .sclk  (sclk),
   .mosi  (mosi),
   .busy  (busy),
   .done  (done)
);

// File: tb/spi_cfg_master_tb_top.sv
module spi_cfg_master_tb_top;
   localparam int W    = 32;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int LAST = HALF + 1 + DIV * (W - 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic [W-1:0] cmd = '0;
   logic         busy, done, csn, sclk, mosi;
   logic [W-1:0] rdata;
   logic         miso = 1'b0;

   int vectors = 0;
   int errors  = 0;
   bit timeout = 1'b0;

   always #10 clk = ~clk;

   spi_cfg_master #(.WORD_W(W), .CLK_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .busy(busy),
      .done(done), .rdata(rdata), .csn(csn), .sclk(sclk), .mosi(mosi),
      .miso(miso)
   );

   // behavioural chip model
   logic [W-1:0] resp_next = '0;
   logic [W-1:0] cur_resp  = '0;
   logic [W-1:0] rx        = '0;
   int           rc        = 0;

   always @(negedge csn) begin
      cur_resp = resp_next;
      rc       = 0;
      rx       = '0;
      miso     = resp_next[W-1];
   end

   always @(posedge sclk) begin
      if (rc < W) begin
         miso <= cur_resp[W-1-rc];
         rx    = {rx[W-2:0], mosi};
         rc    = rc + 1;
      end
   end

   // cycle model: mt counts edges since acceptance, -1 when idle
   int           mt = -1;
   logic [W-1:0] m_cmd = '0;

   always @(posedge clk) begin
      if (!rst_n) mt = -1;
      else if (mt < 0) begin
         if (req) begin
            mt    = 0;
            m_cmd = cmd;
         end
      end else begin
         mt = mt + 1;
         if (mt == LAST + DIV) mt = -1;
      end
   end

   task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
      end
   endtask

   int hi_run = 0;
   bit seen_xfer = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic e_csn, e_sclk, e_busy, e_done;
         e_csn  = !(mt >= 0 && mt < LAST);
         e_sclk = (mt >= 1 && mt < LAST && ((mt - 1) % DIV) < HALF);
         e_busy = (mt >= 0);
         e_done = (mt == LAST + 1);
         chk("R2 csn", W'(csn), W'(e_csn));
         chk("R3 sclk", W'(sclk), W'(e_sclk));
         chk("R8 busy", W'(busy), W'(e_busy));
         chk("R6 done", W'(done), W'(e_done));
         if (e_done) begin
            chk("R5 rdata", rdata, cur_resp);
            chk("R4 mosi word", rx, m_cmd);
         end
         if (csn) hi_run++;
         else begin
            if (hi_run > 0 && seen_xfer) chk("R7 deselect", W'(hi_run >= DIV + 1), W'(1));
            seen_xfer = 1'b1;
            hi_run = 0;
         end
      end
   end

   task automatic xfer(input logic [W-1:0] c, input logic [W-1:0] r);
      @(negedge clk); #1;
      resp_next = r;
      cmd = c;
      req = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      repeat (LAST + DIV + 4) @(negedge clk);
   endtask

   task automatic run_tests();
      repeat (3) @(negedge clk);
      // R1: reset state, sampled while reset is held
      chk("R1 csn", W'(csn), W'(1));
      chk("R1 sclk", W'(sclk), W'(0));
      chk("R1 busy", W'(busy), W'(0));
      chk("R1 done", W'(done), W'(0));
      chk("R1 rdata", rdata, '0);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);

      xfer(32'hA5A5_F00F, 32'h3C3C_0FF0);
      xfer(32'hFFFF_FFFF, 32'h0000_0000);
      xfer(32'h8000_0001, 32'h0000_0001);
      chk("R6 rdata held", rdata, 32'h0000_0001);

      // R8: request with another command in the middle of a transfer
      @(negedge clk); #1;
      resp_next = 32'h1234_5678;
      cmd = 32'hCAFE_0042;
      req = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      repeat (40) @(negedge clk);
      #1;
      cmd = 32'hDEAD_BEEF;
      req = 1'b1;
      @(negedge clk); #1;
      req = 1'b0;
      cmd = '0;
      repeat (LAST + DIV + 10) @(negedge clk);
      chk("R8 no extra transfer", W'(busy), W'(0));
      chk("R8 original result", rdata, 32'h1234_5678);

      // R7: req held high across two transfers
      @(negedge clk); #1;
      resp_next = 32'h0F0F_AAAA;
      cmd = 32'h5555_0F0F;
      req = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      cmd = 32'h0000_8001;
      resp_next = 32'hF00D_0003;
      repeat (LAST + DIV + 2) @(negedge clk);
      #1 req = 1'b0;
      repeat (LAST + DIV + 6) @(negedge clk);
      chk("R7 second result", rdata, 32'hF00D_0003);
      chk("R7 idle after pair", W'(busy), W'(0));
      // R9 is an elaboration-time rule on the parameters
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (200000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      if (timeout) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule